// File: doc/BRIEF.md
# Nibble Accumulator Sequencer

This block is the control and register core of a very small 4-bit processor. Each instruction is one byte. The upper nibble is the opcode and the lower nibble is a single parameter. Depending on the opcode, the parameter is used either as a literal value or as an index into a sixteen-entry register file. The core reads instruction memory combinationally at the address held in its instruction-pointer register. It executes the data-movement, clear, memory, conditional-jump and halt opcodes itself. For opcodes 1 to 8 it passes operands to an external arithmetic unit and writes back what that unit returns.

Data memory sits outside the block and has a synchronous read. A load therefore takes two cycles: one to issue the read and one to write the returned nibble back. Memory is addressed as the address-base register plus the literal, modulo 16. A conditional jump tests the literal as a mask against the status register. When it is taken, the jump target comes from the address-base register. A halt opcode stops the core for good and presents its literal as a return value until the next reset.

Top module: `nibble_seq`

## Requirements
- R1: While reset is low, every register is cleared. After reset the core fetches from address 0 with `done` low.
- R2: Opcode 0 raises `done` in the following cycle and drives `ret_val` with the literal. `done` and `ret_val` then hold until reset, and no memory strobe, arithmetic request or instruction-pointer change occurs after that.
- R3: Opcode 9 writes the literal into the register whose index is held in register 2 (the load/store selector, 0 after reset, meaning the accumulator). It sets status from that value.
- R4: Opcode A raises `dmem_re` for one cycle at address (reg3 + literal) mod 16. In the next cycle it writes the returned nibble into the register selected by register 2 and sets status from it. Across both cycles the instruction pointer stays put, and it advances only after the writeback.
- R5: Opcode B raises `dmem_we` for one cycle at address (reg3 + literal) mod 16, with `dmem_wdata` equal to the register selected by register 2.
- R6: Opcode C copies register[literal] into the accumulator (register 0). Opcode D copies the accumulator into register[literal]. Both set status from the copied value.
- R7: Opcode E loads the instruction pointer from register 3 when (literal AND status) is nonzero, and otherwise falls through. A literal of 0 therefore never jumps.
- R8: Opcode F writes zero into register[literal] and sets status from zero.
- R9: For opcodes 1 to 8 the core raises `alu_valid` with `alu_op` equal to the opcode, `alu_a` equal to the accumulator and `alu_b` equal to register[literal]. Opcodes 1 to 7 write `alu_result` into the accumulator. All eight copy `alu_flags` into status. At most one of `dmem_re`, `dmem_we` and `alu_valid` is high in any cycle.
- R10: Status derived from a value v is encoded as bit0 = (v == 0), bit1 = v[3], bit2 = v[0], bit3 = 0. When an instruction writes register 1 (status) and also updates status, the status update wins.
- R11: Register 4 is the instruction pointer. It advances by one, wrapping from 15 to 0, after each instruction that neither jumps nor writes register 4. An instruction that writes register 4 sets the next fetch address to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 4 | Instruction fetch address (register 4) |
| imem_data | input | 8 | Instruction byte at `imem_addr`, same cycle |
| dmem_addr | output | 4 | Data address, meaningful with a strobe |
| dmem_re | output | 1 | Data read strobe, data returned next cycle |
| dmem_we | output | 1 | Data write strobe |
| dmem_wdata | output | 4 | Write data, meaningful with `dmem_we` |
| dmem_rdata | input | 4 | Read data, one cycle after `dmem_re` |
| alu_valid | output | 1 | Arithmetic request for opcodes 1 to 8 |
| alu_op | output | 4 | Opcode passed to the arithmetic unit |
| alu_a | output | 4 | Accumulator operand |
| alu_b | output | 4 | Indexed-register operand |
| alu_result | input | 4 | Arithmetic result, same cycle |
| alu_flags | input | 4 | Status produced by the arithmetic unit |
| done | output | 1 | Core has halted |
| ret_val | output | 4 | Literal of the halting instruction |

## Verification
The hardest situation to reach from the ports is a jump whose outcome depends on state built up during an earlier pass, after the instruction pointer has wrapped from 15 back to 0. To get there, the program first skips over its own halt with a taken jump. It then arms a general register and lets execution run off the end of memory, so that on the second pass the same mask test at address 1 goes the other way. Priority between a status update and an explicit write to register 1 is exposed by copying the status register back into the accumulator and storing it.

// File: rtl/nibble_seq_pkg.sv
// Shared definitions for the nibble sequencer: opcode and state encodings,
// fixed register indices and the status derivation used by the core.
// Assumes a 4-bit data path; register indices are architectural.
package nibble_seq_pkg;

    localparam int NIB      = 4;
    localparam int IDX_ACC  = 0;
    localparam int IDX_STS  = 1;
    localparam int IDX_SEL  = 2;
    localparam int IDX_BASE = 3;
    localparam int IDX_IP   = 4;

    typedef enum logic [NIB-1:0] {
        OP_HALT = 4'h0, OP_ADD = 4'h1, OP_SUB = 4'h2, OP_MUL = 4'h3,
        OP_DIV  = 4'h4, OP_AND = 4'h5, OP_IOR = 4'h6, OP_XOR = 4'h7,
        OP_CMP  = 4'h8, OP_LIT = 4'h9, OP_LOAD = 4'hA, OP_STORE = 4'hB,
        OP_GET  = 4'hC, OP_PUT = 4'hD, OP_BR = 4'hE, OP_CLR = 4'hF
    } op_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WB   = 2'd1,
        ST_HALT = 2'd2
    } state_e;

    // Status nibble derived from a value: zero, sign, odd, spare.
    function automatic logic [NIB-1:0] flags_of(input logic [NIB-1:0] v);
        return {1'b0, v[0], v[NIB-1], (v == '0)};
    endfunction

endpackage

// File: rtl/nibble_seq_regfile.sv
// Sixteen-entry register file of the sequencer.
// One general write port, a status port that overrides writes to the
// status register, and an instruction-pointer port that a general write to
// the instruction-pointer register overrides. Synchronous active-low reset
// clears everything. All registers are visible in parallel.
module nibble_seq_regfile
    import nibble_seq_pkg::*;
#(
    parameter int W    = NIB,
    parameter int NREG = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(NREG)-1:0]   wr_idx,
    input  logic [W-1:0]              wr_data,
    input  logic                      sts_en,
    input  logic [W-1:0]              sts_data,
    input  logic                      ip_en,
    input  logic [W-1:0]              ip_data,
    output logic [NREG-1:0][W-1:0]    regs
);

    localparam int IW = $clog2(NREG);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Per-register update with status and explicit-write priorities.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (i == IDX_STS && sts_en) begin
                regs[i] <= sts_data;
            end else if (wr_en && wr_idx == IW'(i)) begin
                regs[i] <= wr_data;
            end else if (i == IDX_IP && ip_en) begin
                regs[i] <= ip_data;
            end
        end
    end

endmodule

// File: rtl/nibble_seq_exec.sv
// Combinational execute stage: decodes the fetched byte against the current
// state and register contents and produces register-file writes, memory and
// arithmetic requests, and the next-state requests for the control FSM.
// Assumes instruction byte = {opcode, literal}, each W bits wide.
module nibble_seq_exec
    import nibble_seq_pkg::*;
#(
    parameter int W    = NIB,
    parameter int NREG = 16
) (
    input  state_e                    state,
    input  logic [2*W-1:0]            instr,
    input  logic [NREG-1:0][W-1:0]    regs,
    input  logic [W-1:0]              alu_result,
    input  logic [W-1:0]              alu_flags,
    input  logic [W-1:0]              dmem_rdata,
    output logic                      wr_en,
    output logic [$clog2(NREG)-1:0]   wr_idx,
    output logic [W-1:0]              wr_data,
    output logic                      sts_en,
    output logic [W-1:0]              sts_data,
    output logic                      ip_en,
    output logic [W-1:0]              ip_data,
    output logic                      dmem_re,
    output logic                      dmem_we,
    output logic [W-1:0]              dmem_addr,
    output logic [W-1:0]              dmem_wdata,
    output logic                      alu_valid,
    output logic [W-1:0]              alu_op,
    output logic [W-1:0]              alu_a,
    output logic [W-1:0]              alu_b,
    output logic                      go_wb,
    output logic                      go_halt
);

    localparam int IW = $clog2(NREG);

    op_e          op;
    logic [W-1:0] lit;
    logic [W-1:0] acc;
    logic [W-1:0] sel;

    assign op         = op_e'(instr[2*W-1:W]);
    assign lit        = instr[W-1:0];
    assign acc        = regs[IDX_ACC];
    assign sel        = regs[IDX_SEL];
    assign dmem_addr  = regs[IDX_BASE] + lit;
    assign dmem_wdata = regs[sel];
    assign alu_op     = instr[2*W-1:W];
    assign alu_a      = acc;
    assign alu_b      = regs[lit];

    // Decode the current instruction or load writeback into control actions.
    always_comb begin
        wr_en     = 1'b0;
        wr_idx    = '0;
        wr_data   = '0;
        sts_en    = 1'b0;
        sts_data  = '0;
        ip_en     = 1'b0;
        ip_data   = regs[IDX_IP] + 1'b1;
        dmem_re   = 1'b0;
        dmem_we   = 1'b0;
        alu_valid = 1'b0;
        go_wb     = 1'b0;
        go_halt   = 1'b0;
        unique case (state)
            ST_WB: begin
                wr_en    = 1'b1;
                wr_idx   = IW'(sel);
                wr_data  = dmem_rdata;
                sts_en   = 1'b1;
                sts_data = flags_of(dmem_rdata);
                ip_en    = 1'b1;
            end
            ST_RUN: begin
                ip_en = 1'b1;
                unique case (op)
                    OP_HALT: begin
                        ip_en   = 1'b0;
                        go_halt = 1'b1;
                    end
                    OP_ADD, OP_SUB, OP_MUL, OP_DIV,
                    OP_AND, OP_IOR, OP_XOR: begin
                        alu_valid = 1'b1;
                        wr_en     = 1'b1;
                        wr_idx    = IW'(IDX_ACC);
                        wr_data   = alu_result;
                        sts_en    = 1'b1;
                        sts_data  = alu_flags;
                    end
                    OP_CMP: begin
                        alu_valid = 1'b1;
                        sts_en    = 1'b1;
                        sts_data  = alu_flags;
                    end
                    OP_LIT: begin
                        wr_en    = 1'b1;
                        wr_idx   = IW'(sel);
                        wr_data  = lit;
                        sts_en   = 1'b1;
                        sts_data = flags_of(lit);
                    end
                    OP_LOAD: begin
                        ip_en   = 1'b0;
                        dmem_re = 1'b1;
                        go_wb   = 1'b1;
                    end
                    OP_STORE: begin
                        dmem_we = 1'b1;
                    end
                    OP_GET: begin
                        wr_en    = 1'b1;
                        wr_idx   = IW'(IDX_ACC);
                        wr_data  = regs[lit];
                        sts_en   = 1'b1;
                        sts_data = flags_of(regs[lit]);
                    end
                    OP_PUT: begin
                        wr_en    = 1'b1;
                        wr_idx   = IW'(lit);
                        wr_data  = acc;
                        sts_en   = 1'b1;
                        sts_data = flags_of(acc);
                    end
                    OP_BR: begin
                        if ((lit & regs[IDX_STS]) != '0) begin
                            ip_data = regs[IDX_BASE];
                        end
                    end
                    OP_CLR: begin
                        wr_en    = 1'b1;
                        wr_idx   = IW'(lit);
                        wr_data  = '0;
                        sts_en   = 1'b1;
                        sts_data = flags_of('0);
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nibble_seq.sv
// Top of the nibble accumulator sequencer. Holds the control state
// (run, load writeback, halted) and the return value, and wires the
// execute stage to the register file. Instruction memory is read
// combinationally at the instruction pointer; data memory reads return one
// cycle after the strobe. Synchronous active-low reset.
module nibble_seq
    import nibble_seq_pkg::*;
#(
    parameter int W    = NIB,
    parameter int NREG = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [3:0]   imem_addr,
    input  logic [7:0]   imem_data,
    output logic [3:0]   dmem_addr,
    output logic         dmem_re,
    output logic         dmem_we,
    output logic [3:0]   dmem_wdata,
    input  logic [3:0]   dmem_rdata,
    output logic         alu_valid,
    output logic [3:0]   alu_op,
    output logic [3:0]   alu_a,
    output logic [3:0]   alu_b,
    input  logic [3:0]   alu_result,
    input  logic [3:0]   alu_flags,
    output logic         done,
    output logic [3:0]   ret_val
);

    localparam int IW = $clog2(NREG);

    state_e                 state;
    logic [W-1:0]           ret_q;
    logic [NREG-1:0][W-1:0] regs;
    logic                   wr_en, sts_en, ip_en, go_wb, go_halt;
    logic [IW-1:0]          wr_idx;
    logic [W-1:0]           wr_data, sts_data, ip_data;

    assign imem_addr = regs[IDX_IP];
    assign done      = (state == ST_HALT);
    assign ret_val   = ret_q;

    nibble_seq_exec #(.W(W), .NREG(NREG)) u_exec (
        .state      (state),
        .instr      (imem_data),
        .regs       (regs),
        .alu_result (alu_result),
        .alu_flags  (alu_flags),
        .dmem_rdata (dmem_rdata),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .sts_en     (sts_en),
        .sts_data   (sts_data),
        .ip_en      (ip_en),
        .ip_data    (ip_data),
        .dmem_re    (dmem_re),
        .dmem_we    (dmem_we),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .alu_valid  (alu_valid),
        .alu_op     (alu_op),
        .alu_a      (alu_a),
        .alu_b      (alu_b),
        .go_wb      (go_wb),
        .go_halt    (go_halt)
    );

    nibble_seq_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .sts_en   (sts_en),
        .sts_data (sts_data),
        .ip_en    (ip_en),
        .ip_data  (ip_data),
        .regs     (regs)
    );

    // Control state: run, load writeback, permanent halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else if (go_halt) begin
            state <= ST_HALT;
        end else if (go_wb) begin
            state <= ST_WB;
        end else if (state == ST_WB) begin
            state <= ST_RUN;
        end
    end

    // Capture the literal of the halting instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q <= '0;
        end else if (go_halt) begin
            ret_q <= imem_data[W-1:0];
        end
    end

endmodule

// File: rtl/nibble_seq_checks.sv
// Port-level temporal checks for the nibble sequencer, bound to its top.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module nibble_seq_checks (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] imem_addr,
    input logic       dmem_re,
    input logic       dmem_we,
    input logic       alu_valid,
    input logic       done,
    input logic [3:0] ret_val
);

    p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(ret_val)));

    p_halt_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(dmem_re || dmem_we || alu_valid));

    p_load_two_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_re |=> (!dmem_re && !dmem_we && !alu_valid && !done && $stable(imem_addr)));

    p_store_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> (!done && imem_addr == $past(imem_addr) + 4'd1));

    p_one_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dmem_re, dmem_we, alu_valid}));

    p_alu_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        alu_valid |=> (imem_addr == $past(imem_addr) + 4'd1));

endmodule

bind nibble_seq nibble_seq_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .dmem_re   (dmem_re),
    .dmem_we   (dmem_we),
    .alu_valid (alu_valid),
    .done      (done),
    .ret_val   (ret_val)
);

// File: tb/nibble_seq_test.sv
// Bench: behavioural reference model compared on every clock, plus
// hand-computed expectations for stores, return values and control flow.
module nibble_seq_test;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       clr_mem = 1'b1;
    logic [7:0] imem [16];
    logic [3:0] bmem [16];
    logic [3:0] rdq;

    logic [3:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
    logic [3:0] alu_op, alu_a, alu_b, alu_result, alu_flags, ret_val;
    logic [7:0] imem_data;
    logic       dmem_re, dmem_we, alu_valid, done;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    nibble_seq uut (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_we(dmem_we),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .alu_valid(alu_valid), .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
        .alu_result(alu_result), .alu_flags(alu_flags),
        .done(done), .ret_val(ret_val)
    );

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = rdq;

    // Synchronous data memory seen by the design.
    always @(posedge clk) begin
        if (clr_mem) begin
            for (int i = 0; i < 16; i++) bmem[i] <= 4'd0;
            rdq <= 4'd0;
        end else begin
            if (dmem_we) bmem[dmem_addr] <= dmem_wdata;
            if (dmem_re) rdq <= bmem[dmem_addr];
        end
    end

    function automatic logic [7:0] alu_fn(input logic [3:0] op, input logic [3:0] a, input logic [3:0] b);
        logic [3:0] r;
        logic [3:0] f;
        case (op)
            4'd1: r = a + b;
            4'd2: r = a - b;
            4'd3: r = a * b;
            4'd4: r = (b == 4'd0) ? 4'hF : a / b;
            4'd5: r = a & b;
            4'd6: r = a | b;
            4'd7: r = a ^ b;
            default: r = a;
        endcase
        f = {1'b0, r[0], r[3], (r == 4'd0)};
        if (op == 4'd8) f = {1'b0, (a < b), a[3], (a == 4'd0)};
        return {r, f};
    endfunction

    always_comb {alu_result, alu_flags} = alu_fn(alu_op, alu_a, alu_b);

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 20000) begin
            $display("FAIL watchdog expired: got %0d cycles expected fewer than 20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail + 1);
            $finish;
        end
    end

    // Reference model state.
    int mr [16];
    int mst;
    int mret;
    int maddr;
    int mm [16];
    int slog [$];
    int visited [16];
    int saw_wrap;
    int busy;

    function automatic int fl(input int v);
        int x;
        x = v & 15;
        return ((x & 1) << 2) | (((x >> 3) & 1) << 1) | ((x == 0) ? 1 : 0);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string op_tag(input int op);
        case (op)
            0: return "R2";
            9: return "R3";
            10: return "R4";
            11: return "R5";
            12, 13: return "R6";
            14: return "R7";
            15: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Compare every port against the model for the current cycle.
    task automatic compare();
        int ip, op, nx;
        bit ere, ewe, eav, edn;
        string tag;
        ip  = mr[4];
        op  = imem[ip][7:4];
        nx  = imem[ip][3:0];
        ere = (mst == 0) && (op == 10);
        ewe = (mst == 0) && (op == 11);
        eav = (mst == 0) && (op >= 1) && (op <= 8);
        edn = (mst == 2);
        tag = (mst == 2) ? "R2" : (mst == 1) ? "R4" : op_tag(op);
        chk(imem_addr == ip[3:0], "R11", "fetch address", imem_addr, ip);
        chk(done == edn, tag, "done", done, edn);
        if (edn) chk(ret_val == mret[3:0], "R2", "return value", ret_val, mret);
        chk(dmem_re == ere, tag, "read strobe", dmem_re, ere);
        chk(dmem_we == ewe, tag, "write strobe", dmem_we, ewe);
        chk(alu_valid == eav, tag, "alu request", alu_valid, eav);
        if (ere || ewe) chk(dmem_addr == 4'((mr[3] + nx) & 15), tag, "data address", dmem_addr, (mr[3] + nx) & 15);
        if (ewe) chk(dmem_wdata == 4'(mr[mr[2]]), tag, "write data", dmem_wdata, mr[mr[2]]);
        if (eav) begin
            chk(alu_op == 4'(op), "R9", "alu opcode", alu_op, op);
            chk(alu_a == 4'(mr[0]), "R9", "alu operand a", alu_a, mr[0]);
            chk(alu_b == 4'(mr[nx]), "R9", "alu operand b", alu_b, mr[nx]);
        end
        if (dmem_we) slog.push_back(dmem_addr * 16 + dmem_wdata);
        if (!done) busy++;
        visited[imem_addr] = 1;
    endtask

    // Advance the model by one clock.
    task automatic step();
        int ip, op, nx, nip, d, v;
        logic [7:0] af;
        ip  = mr[4];
        op  = imem[ip][7:4];
        nx  = imem[ip][3:0];
        nip = (ip + 1) & 15;
        if (mst == 2) return;
        if (mst == 1) begin
            d = mr[2]; v = mm[maddr];
            mr[d] = v; mr[1] = fl(v);
            if (d != 4) mr[4] = nip;
            mst = 0;
            return;
        end
        case (op)
            0: begin mst = 2; mret = nx; end
            10: begin maddr = (mr[3] + nx) & 15; mst = 1; end
            11: begin mm[(mr[3] + nx) & 15] = mr[mr[2]]; mr[4] = nip; end
            9: begin
                d = mr[2]; mr[d] = nx; mr[1] = fl(nx);
                if (d != 4) mr[4] = nip;
            end
            12: begin v = mr[nx]; mr[0] = v; mr[1] = fl(v); mr[4] = nip; end
            13: begin
                v = mr[0]; mr[nx] = v; mr[1] = fl(v);
                if (nx != 4) mr[4] = nip;
            end
            14: mr[4] = ((nx & mr[1]) != 0) ? mr[3] : nip;
            15: begin
                mr[nx] = 0; mr[1] = fl(0);
                if (nx != 4) mr[4] = nip;
            end
            default: begin
                af = alu_fn(4'(op), 4'(mr[0]), 4'(mr[nx]));
                if (op != 8) mr[0] = af[7:4];
                mr[1] = af[3:0];
                mr[4] = nip;
            end
        endcase
    endtask

    task automatic run_prog(input int maxc);
        int post;
        rst_n = 1'b0;
        clr_mem = 1'b1;
        for (int i = 0; i < 16; i++) begin mr[i] = 0; mm[i] = 0; visited[i] = 0; end
        mst = 0; mret = 0; maddr = 0; busy = 0; saw_wrap = 0;
        slog.delete();
        repeat (3) @(posedge clk);
        @(negedge clk);
        clr_mem = 1'b0;
        rst_n = 1'b1;
        chk(imem_addr == 4'd0 && done == 1'b0, "R1", "fetch/done after reset", {imem_addr, 3'b0, done}, 0);
        post = 0;
        for (int n = 0; n < maxc && post < 4; n++) begin
            int prev;
            prev = imem_addr;
            compare();
            step();
            if (mst == 2) post++;
            @(negedge clk);
            if (prev == 15 && imem_addr == 4'd0) saw_wrap = 1;
        end
    endtask

    task automatic chk_store(input int k, input int a, input int d, input string tag);
        int got;
        got = (k < slog.size()) ? slog[k] : -1;
        chk(got == a * 16 + d, tag, "store (addr*16+data)", got, a * 16 + d);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) imem[i] = 8'h00;

        // P1: reset state, literal load via selector, copies, clear.
        imem[0] = 8'hB0; imem[1] = 8'h96; imem[2] = 8'hD7; imem[3] = 8'hF0;
        imem[4] = 8'hC7; imem[5] = 8'hB1; imem[6] = 8'h95; imem[7] = 8'hD2;
        imem[8] = 8'h9B; imem[9] = 8'hB2; imem[10] = 8'hF5; imem[11] = 8'hB3;
        imem[12] = 8'h0A; imem[13] = 8'hB9; imem[14] = 8'h00; imem[15] = 8'h00;
        run_prog(60);
        chk_store(0, 0, 0, "R1");
        chk_store(1, 1, 6, "R6");
        chk_store(2, 2, 11, "R3");
        chk_store(3, 3, 0, "R8");
        chk(slog.size() == 4, "R2", "store count", slog.size(), 4);
        chk(ret_val == 4'hA && done, "R2", "halt value", ret_val, 10);

        // P2: wrapped memory addressing, load writeback, status encoding.
        imem[0] = 8'h93; imem[1] = 8'hD3; imem[2] = 8'h9E; imem[3] = 8'hBF;
        imem[4] = 8'hF0; imem[5] = 8'hAF; imem[6] = 8'hB0; imem[7] = 8'hC1;
        imem[8] = 8'hB1; imem[9] = 8'hF1; imem[10] = 8'hC1; imem[11] = 8'hB2;
        imem[12] = 8'hD1; imem[13] = 8'hC1; imem[14] = 8'hB3; imem[15] = 8'h05;
        run_prog(60);
        chk_store(0, 2, 14, "R5");
        chk_store(1, 3, 14, "R4");
        chk_store(2, 4, 2, "R10");
        chk_store(3, 5, 1, "R10");
        chk_store(4, 6, 4, "R10");
        chk(ret_val == 4'd5, "R2", "halt value", ret_val, 5);

        // P3: skip over halt by jump, wrap 15->0, second-pass jump.
        imem[0] = 8'hC5; imem[1] = 8'hE4; imem[2] = 8'h91; imem[3] = 8'hD5;
        imem[4] = 8'hE0; imem[5] = 8'hE0; imem[6] = 8'h9B; imem[7] = 8'hD3;
        imem[8] = 8'hE2; imem[9] = 8'hE0; imem[10] = 8'h09; imem[11] = 8'h9A;
        imem[12] = 8'hD3; imem[13] = 8'hE0; imem[14] = 8'hE0; imem[15] = 8'hE0;
        run_prog(80);
        chk(ret_val == 4'd9 && done, "R7", "second-pass jump target", ret_val, 9);
        chk(visited[9] == 0, "R7", "skipped address visited", visited[9], 0);
        chk(visited[5] == 1, "R7", "mask-0 fall through", visited[5], 1);
        chk(saw_wrap == 1, "R11", "wrap 15 to 0", saw_wrap, 1);
        chk(busy == 17, "R11", "cycles before halt", busy, 17);

        // P4: arithmetic handoff and write to the instruction pointer.
        imem[0] = 8'h96; imem[1] = 8'hD6; imem[2] = 8'h93; imem[3] = 8'h16;
        imem[4] = 8'hB0; imem[5] = 8'h26; imem[6] = 8'h36; imem[7] = 8'h76;
        imem[8] = 8'h86; imem[9] = 8'hB1; imem[10] = 8'h9E; imem[11] = 8'hD4;
        imem[12] = 8'h01; imem[13] = 8'h02; imem[14] = 8'hB2; imem[15] = 8'h03;
        run_prog(60);
        chk_store(0, 0, 9, "R9");
        chk_store(1, 1, 4, "R9");
        chk_store(2, 2, 14, "R11");
        chk(ret_val == 4'd3, "R11", "halt after pointer write", ret_val, 3);

        // P5: immediate halt; nothing after it executes.
        imem[0] = 8'h0C; imem[1] = 8'hB0; imem[2] = 8'hB1;
        run_prog(20);
        chk(slog.size() == 0, "R2", "stores after halt", slog.size(), 0);
        chk(ret_val == 4'hC && done && imem_addr == 4'd0, "R2", "halt held", ret_val, 12);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule